// File: doc/BRIEF.md
# Packed Byte Media Operation Unit

This block is an execution unit for pixel work. Each operand word is treated as a row of unsigned byte lanes, and one operation per transfer is applied to those lanes. A 3-bit opcode selects the operation. The choices are a saturating lane-wise add, a lane-wise average that rounds up, a sum of absolute differences across all lanes (a cost term for motion search), an unsigned lane-wise dot product, and a clamp of a signed scalar into the range from zero to an unsigned limit. Every operation except the clamp works on lanes.

Operands arrive on a valid/ready stream and results leave on a second valid/ready stream. One output register sits between the two streams. An operation is accepted when `in_valid` and `in_ready` are both high at a rising clock edge. Its result appears in the next cycle and stays in place until the consumer takes it. While a result is waiting and the consumer holds `out_ready` low, the unit lowers `in_ready`, so back-pressure passes straight through to the producer. An opcode outside the defined set is still accepted, but it produces no output transfer.

Top module: `pbmu_top`

## Requirements
- R1: Lane i occupies bits [8i+7:8i], with lane 3 in bits 31:24 and lane 0 in bits 7:0. Opcode 0 adds each pair of lanes and saturates the result at 255. No carry passes from one lane into the next.
- R2: Opcode 1 writes (a+b+1)>>1 into each lane, computed without loss of the ninth bit.
- R3: Opcode 2 returns the sum of |a_i - b_i| over the four lanes, zero-extended to 32 bits.
- R4: Opcode 3 returns a3*b3 + a2*b2 + a1*b1 + a0*b0, with every lane taken as unsigned, as the full 32-bit sum.
- R5: Opcode 4 treats in_a as signed 32-bit and in_b as unsigned 32-bit. It returns 0 when in_a is negative, returns in_b when in_a is greater than in_b, and returns in_a in all other cases.
- R6: An accepted opcode of 5, 6 or 7 leaves out_valid low and out_data zero in the next cycle.
- R7: An accepted operation with a defined opcode makes out_valid high with its result in the cycle after acceptance.
- R8: While out_valid is high and out_ready is low, in_ready is low, and out_valid and out_data hold their values.
- R9: During reset, out_valid is low and out_data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation |
| in_op | input | 3 | Operation select |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 32 | Result word |

## Verification
The bench builds the unit with its default parameters: four lanes of eight bits. With these values, the saturation point of 255, the rounding carry at 255+255, a difference sum of 1020 and a dot product of 260100 can all be reached with directed operands. The 32-bit width of the clamp comparison also allows sign-bit and full-range limits to be applied directly. A random mix that includes the undefined opcodes runs alongside a stalled consumer, so that acceptance, dropping and holding are each exercised with real data.

// File: rtl/pbmu_pkg.sv
package pbmu_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_AVG  = 3'd1,
    OP_SAD  = 3'd2,
    OP_DOT  = 3'd3,
    OP_CLIP = 3'd4
  } pbmu_op_e;

  localparam logic [2:0] OP_LAST = 3'd4;

  function automatic logic op_defined(input logic [2:0] op);
    return op <= OP_LAST;
  endfunction
endpackage

// File: rtl/pbmu_lane.sv
module pbmu_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   sat_sum,
  output logic [W-1:0]   avg_up,
  output logic [W-1:0]   abs_diff,
  output logic [2*W-1:0] prod
);
  logic [W:0] wide_sum;
  logic [W:0] round_sum;

  always_comb begin
    wide_sum  = {1'b0, a} + {1'b0, b};
    round_sum = wide_sum + {{W{1'b0}}, 1'b1};
    sat_sum   = wide_sum[W] ? {W{1'b1}} : wide_sum[W-1:0];
    avg_up    = round_sum[W:1];
    abs_diff  = (a >= b) ? (a - b) : (b - a);
    prod      = {{W{1'b0}}, a} * {{W{1'b0}}, b};
  end
endmodule

// File: rtl/pbmu_reduce.sv
module pbmu_reduce #(
  parameter int W     = 8,
  parameter int LANES = 4,
  parameter int OUT_W = 32
) (
  input  logic [LANES*W-1:0]   diffs,
  input  logic [LANES*2*W-1:0] prods,
  output logic [OUT_W-1:0]     sad_sum,
  output logic [OUT_W-1:0]     dot_sum
);
  always_comb begin
    sad_sum = '0;
    dot_sum = '0;
    for (int i = 0; i < LANES; i++) begin
      sad_sum = sad_sum + {{(OUT_W-W){1'b0}}, diffs[i*W +: W]};
      dot_sum = dot_sum + {{(OUT_W-2*W){1'b0}}, prods[i*2*W +: 2*W]};
    end
  end
endmodule

// File: rtl/pbmu_clip.sv
module pbmu_clip #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] value,
  input  logic [DW-1:0] bound,
  output logic [DW-1:0] clipped
);
  always_comb begin
    if (value[DW-1])        clipped = '0;
    else if (value > bound) clipped = bound;
    else                    clipped = value;
  end
endmodule

// File: rtl/pbmu_top.sv
module pbmu_top
  import pbmu_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int LANES  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [2:0]               in_op,
  input  logic [LANE_W*LANES-1:0]  in_a,
  input  logic [LANE_W*LANES-1:0]  in_b,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [LANE_W*LANES-1:0]  out_data
);
  localparam int DATA_W = LANE_W * LANES;

  logic [DATA_W-1:0]         add_word, avg_word, diff_word;
  logic [2*LANE_W*LANES-1:0] prod_word;
  logic [DATA_W-1:0]         sad_sum, dot_sum, clip_val;
  logic [DATA_W-1:0]         result;
  logic                      take;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    pbmu_lane #(.W(LANE_W)) u_lane (
      .a        (in_a[g*LANE_W +: LANE_W]),
      .b        (in_b[g*LANE_W +: LANE_W]),
      .sat_sum  (add_word[g*LANE_W +: LANE_W]),
      .avg_up   (avg_word[g*LANE_W +: LANE_W]),
      .abs_diff (diff_word[g*LANE_W +: LANE_W]),
      .prod     (prod_word[g*2*LANE_W +: 2*LANE_W])
    );
  end

  pbmu_reduce #(.W(LANE_W), .LANES(LANES), .OUT_W(DATA_W)) u_reduce (
    .diffs   (diff_word),
    .prods   (prod_word),
    .sad_sum (sad_sum),
    .dot_sum (dot_sum)
  );

  pbmu_clip #(.DW(DATA_W)) u_clip (
    .value   (in_a),
    .bound   (in_b),
    .clipped (clip_val)
  );

  always_comb begin
    case (in_op)
      OP_ADD:  result = add_word;
      OP_AVG:  result = avg_word;
      OP_SAD:  result = sad_sum;
      OP_DOT:  result = dot_sum;
      OP_CLIP: result = clip_val;
      default: result = '0;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= op_defined(in_op);
      out_data  <= result;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pbmu_checker.sv
module pbmu_checker #(
  parameter int LANE_W = 8,
  parameter int LANES  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic [2:0]              in_op,
  input logic [LANE_W*LANES-1:0] in_a,
  input logic [LANE_W*LANES-1:0] in_b,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [LANE_W*LANES-1:0] out_data
);
  localparam int DATA_W = LANE_W * LANES;
  localparam logic [DATA_W-1:0] SAD_MAX = DATA_W'(LANES * ((1 << LANE_W) - 1));

  logic acc;
  assign acc = in_valid && in_ready;

  p_reset_r9: assert property (@(posedge clk) !rst_n |=> !out_valid && out_data == '0);

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op <= 3'd4 |=> out_valid);

  p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op > 3'd4 |=> !out_valid && out_data == '0);

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_clip_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 3'd4 |=> out_data <= $past(in_b));

  p_sad_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && in_op == 3'd2 |=> out_data <= SAD_MAX);

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    p_add_floor_r1: assert property (@(posedge clk) disable iff (!rst_n)
      acc && in_op == 3'd0 |=>
        out_data[g*LANE_W +: LANE_W] >= $past(in_a[g*LANE_W +: LANE_W]) &&
        out_data[g*LANE_W +: LANE_W] >= $past(in_b[g*LANE_W +: LANE_W]));

    p_avg_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc && in_op == 3'd1 |=>
        (out_data[g*LANE_W +: LANE_W] >= $past(in_a[g*LANE_W +: LANE_W]) ||
         out_data[g*LANE_W +: LANE_W] >= $past(in_b[g*LANE_W +: LANE_W])) &&
        (out_data[g*LANE_W +: LANE_W] <= $past(in_a[g*LANE_W +: LANE_W]) ||
         out_data[g*LANE_W +: LANE_W] <= $past(in_b[g*LANE_W +: LANE_W])));
  end
endmodule

bind pbmu_top pbmu_checker #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data)
);

// File: tb/tb_pbmu_top.sv
module tb_pbmu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pbmu_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [31:0] model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r = '0;
    for (int i = 0; i < 4; i++) begin
      int x = int'(a[i*8 +: 8]);
      int y = int'(b[i*8 +: 8]);
      case (op)
        3'd0: r[i*8 +: 8] = (x + y > 255) ? 8'hFF : 8'(x + y);
        3'd1: r[i*8 +: 8] = 8'((x + y + 1) / 2);
        3'd2: r = r + 32'((x > y) ? x - y : y - x);
        3'd3: r = r + 32'(x * y);
        default: ;
      endcase
    end
    if (op == 3'd4) begin
      if ($signed(a) < 0) r = 0;
      else if (a > b)     r = b;
      else                r = a;
    end
    return r;
  endfunction

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R1 add";
      3'd1: return "R2 avg";
      3'd2: return "R3 sad";
      3'd3: return "R4 dot";
      3'd4: return "R5 clip";
      default: return "R6 undefined op";
    endcase
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] exp = model(op, a, b);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; out_ready = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    if (op <= 3'd4) begin
      check(out_valid, {req_of(op), " / R7 valid"}, {31'd0, out_valid}, 32'd1);
      check(out_data == exp, req_of(op), out_data, exp);
    end else begin
      check(!out_valid && out_data == 0, req_of(op), out_data, 32'd0);
    end
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    check(!out_valid && out_data == 0, "R9 reset state", out_data, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    do_op(3'd0, 32'h00FF_80FF, 32'h0101_8001);
    do_op(3'd0, 32'h1020_3040, 32'h0102_0304);
    do_op(3'd1, 32'hFF01_00FE, 32'hFE00_00FF);
    do_op(3'd2, 32'hFFFF_FFFF, 32'h0000_0000);
    do_op(3'd2, 32'h0A14_1E28, 32'h140A_281E);
    do_op(3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    do_op(3'd3, 32'h0102_0304, 32'h0506_0708);
    do_op(3'd4, 32'hFFFF_FFFB, 32'd100);
    do_op(3'd4, 32'd500, 32'd100);
    do_op(3'd4, 32'd50, 32'd100);
    do_op(3'd4, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    do_op(3'd4, 32'h8000_0000, 32'hFFFF_FFFF);
    do_op(3'd5, 32'h1234_5678, 32'h9ABC_DEF0);
    do_op(3'd7, 32'hFFFF_FFFF, 32'hFFFF_FFFF);

    // R8: stalled consumer holds the result and blocks the producer
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_op = 3'd0; in_a = 32'h0102_0304; in_b = 32'h1010_1010;
    @(posedge clk); #1;
    held = out_data;
    check(out_valid && held == 32'h1112_1314, "R8 first result", held, 32'h1112_1314);
    @(negedge clk);
    in_op = 3'd3; in_a = 32'h0202_0202; in_b = 32'h0303_0303;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      check(!in_ready, "R8 in_ready low while stalled", {31'd0, in_ready}, 32'd0);
      check(out_valid && out_data == held, "R8 result held", out_data, held);
    end
    @(negedge clk); out_ready = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
    check(out_valid && out_data == 32'd24, "R8 second result after release", out_data, 32'd24);

    for (int n = 0; n < 400; n++) begin
      logic [2:0]  op = 3'($urandom_range(0, 7));
      logic [31:0] a  = $urandom;
      logic [31:0] b  = (op == 3'd4 && n % 2 == 0) ? 32'($urandom_range(0, 1000)) : $urandom;
      do_op(op, a, b);
    end

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule